// File: doc/BRIEF.md
# Capture/Reload Timer with Baud Output

A 16-bit timer/counter behind a byte-wide register bus. It advances on every core clock or on each falling edge of an external count pin. An external trigger pin can either copy the running count into a 16-bit capture/reload register or reload the count from it. A baud mode supplies receive and transmit rate pulses to a serial port, using overflow-driven auto-reload.

Software reads and writes a control byte and four data bytes: the count high and low bytes and the capture/reload high and low bytes. Two status flags live in the control byte. Only hardware sets them and only software clears them. Their OR drives the interrupt request. Both pins pass through a two-flop synchronizer and a falling-edge detector before the timer logic sees them.

Top module: `cr_timer16`

## Requirements
- R1: After reset every register reads 00h, and `irq`, `rx_baud` and `tx_baud` are 0.
- R2: The register map is: control at C8h, count high at CDh, count low at CCh, capture/reload high at CBh, capture/reload low at CAh. A write with `reg_wr`=1 takes effect at the next clock edge. `reg_rdata` shows the addressed register combinationally, and any other address reads 00h.
- R3: The control byte has these bits: run at bit 2, counter select at bit 1, capture select at bit 0. With run=1 and counter select=0, the count rises by one on every clock edge. Once a write clears run, the count stays where it is.
- R4: With run=1 and counter select=1, each falling edge of `cnt_pin` adds one to the count. The increment appears on the third rising clock edge after the pin falls.
- R5: When the count overflows from FFFFh with capture select=1 and no baud enable, the count wraps to 0000h and the overflow flag (control bit 7) is set.
- R6: When the count overflows with capture select=0, the count loads the capture/reload value and the overflow flag is set.
- R7: External enable is control bit 3. With external enable=1 and capture select=1, a falling edge on `trig_pin` copies the count into the capture/reload register and sets the external flag (control bit 6).
- R8: With external enable=1 and capture select=0, a falling edge on `trig_pin` loads the count from the capture/reload register and sets the external flag.
- R9: With external enable=0, a falling edge on `trig_pin` changes neither the count, nor the capture/reload register, nor any flag.
- R10: The receive-clock enable is bit 5 and the transmit-clock enable is bit 4. When either is 1, every overflow reloads the count whatever the capture select. The overflow flag stays clear, and trigger edges are ignored. Each overflow gives a one-cycle pulse on `rx_baud` (bit 5 set) and/or `tx_baud` (bit 4 set), in the cycle after the overflow.
- R11: A control write with 0 in a flag bit clears that flag. A write with 1 there leaves the flag as it was, so software can never set a flag.
- R12: `irq` is 1 exactly when the overflow flag or the external flag is 1.
- R13: When a count byte is written in the same cycle as an increment, the written byte wins. The other byte keeps its value and no increment is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| cnt_pin | input | 1 | External count input (falling edge) |
| trig_pin | input | 1 | External capture/reload trigger (falling edge) |
| irq | output | 1 | Interrupt request |
| rx_baud | output | 1 | Receive baud pulse |
| tx_baud | output | 1 | Transmit baud pulse |

## Verification
A register write shows in the read data one edge later. From then on, timer-mode counting adds exactly one per edge, so the bench samples at falling clock edges and expects the start value plus the number of edges. Pin edges take three rising edges to act, and the bench checks the count is still unchanged after two and changed after three. Baud pulses are registered, so each one arrives together with the reloaded count; the bench tallies them over a fixed window and compares the total with the overflow count it expects from the reload distance.

// File: rtl/cr_timer_pkg.sv
package cr_timer_pkg;
  localparam logic [7:0] ADDR_CTRL   = 8'hC8;
  localparam logic [7:0] ADDR_CNT_HI = 8'hCD;
  localparam logic [7:0] ADDR_CNT_LO = 8'hCC;
  localparam logic [7:0] ADDR_RLD_HI = 8'hCB;
  localparam logic [7:0] ADDR_RLD_LO = 8'hCA;

  typedef struct packed {
    logic ovf_flag;
    logic ext_flag;
    logic rx_clk_en;
    logic tx_clk_en;
    logic ext_en;
    logic run;
    logic ctr_sel;
    logic cap_sel;
  } ctrl_t;
endpackage

// File: rtl/cr_fall_detect.sv
module cr_fall_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[0] <= 1'b1;
          else        sync_q[0] <= pin;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[g] <= 1'b1;
          else        sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sync_q[SYNC_STAGES-1];

  assign fall = prev_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/cr_count_core.sv
module cr_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             baud_mode,
  input  logic             cap_sel,
  input  logic             ext_evt,
  input  logic             wr_cnt_lo,
  input  logic             wr_cnt_hi,
  input  logic             wr_rld_lo,
  input  logic             wr_rld_hi,
  input  logic [7:0]       wdata,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reload,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int               HI_LSB  = CNT_W - 8;

  logic [CNT_W-1:0] count_q, count_d, reload_q, reload_d;
  logic             cnt_en, rld_en;

  assign ovf = tick && (count_q == CNT_MAX);

  always_comb begin
    count_d = count_q;
    if (wr_cnt_lo)                          count_d[7:0] = wdata;
    else if (wr_cnt_hi)                     count_d[CNT_W-1:HI_LSB] = wdata;
    else if (ext_evt && !cap_sel)           count_d = reload_q;
    else if (ovf && (baud_mode || !cap_sel)) count_d = reload_q;
    else if (tick)                          count_d = count_q + 1'b1;
  end

  always_comb begin
    reload_d = reload_q;
    if (wr_rld_lo)                 reload_d[7:0] = wdata;
    else if (wr_rld_hi)            reload_d[CNT_W-1:HI_LSB] = wdata;
    else if (ext_evt && cap_sel)   reload_d = count_q;
  end

  assign cnt_en = tick | ext_evt | wr_cnt_lo | wr_cnt_hi;
  assign rld_en = ext_evt | wr_rld_lo | wr_rld_hi;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      count_q <= '0;
    else if (cnt_en) count_q <= count_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      reload_q <= '0;
    else if (rld_en) reload_q <= reload_d;

  assign count  = count_q;
  assign reload = reload_q;
endmodule

// File: rtl/cr_timer16.sv
module cr_timer16
  import cr_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       cnt_pin,
  input  logic       trig_pin,
  output logic       irq,
  output logic       rx_baud,
  output logic       tx_baud
);
  localparam int CNT_W = 16;

  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] count_q, reload_q;
  logic             cnt_fall, trig_fall, tick, ovf, ext_evt, baud_mode;
  logic             ovf_set, ext_set, wr_ctrl, ctrl_en;
  logic             rx_q, tx_q;

  cr_fall_detect #(.SYNC_STAGES(SYNC_STAGES)) i_cnt_edge (
    .clk(clk), .rst_n(rst_n), .pin(cnt_pin), .fall(cnt_fall));
  cr_fall_detect #(.SYNC_STAGES(SYNC_STAGES)) i_trig_edge (
    .clk(clk), .rst_n(rst_n), .pin(trig_pin), .fall(trig_fall));

  assign baud_mode = ctrl_q.rx_clk_en | ctrl_q.tx_clk_en;
  assign tick      = ctrl_q.run & (ctrl_q.ctr_sel ? cnt_fall : 1'b1);
  assign ext_evt   = ctrl_q.ext_en & ~baud_mode & trig_fall;

  cr_count_core #(.CNT_W(CNT_W)) i_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .baud_mode(baud_mode),
    .cap_sel(ctrl_q.cap_sel), .ext_evt(ext_evt),
    .wr_cnt_lo(reg_wr && reg_addr == ADDR_CNT_LO),
    .wr_cnt_hi(reg_wr && reg_addr == ADDR_CNT_HI),
    .wr_rld_lo(reg_wr && reg_addr == ADDR_RLD_LO),
    .wr_rld_hi(reg_wr && reg_addr == ADDR_RLD_HI),
    .wdata(reg_wdata), .count(count_q), .reload(reload_q), .ovf(ovf));

  assign ovf_set = ovf & ~baud_mode;
  assign ext_set = ext_evt;
  assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d          = ctrl_t'(reg_wdata);
      ctrl_d.ovf_flag = ctrl_q.ovf_flag & reg_wdata[7];
      ctrl_d.ext_flag = ctrl_q.ext_flag & reg_wdata[6];
    end
    if (ovf_set) ctrl_d.ovf_flag = 1'b1;
    if (ext_set) ctrl_d.ext_flag = 1'b1;
  end

  assign ctrl_en = wr_ctrl | ovf_set | ext_set;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_q <= 1'b0;
      tx_q <= 1'b0;
    end else begin
      rx_q <= ovf & ctrl_q.rx_clk_en;
      tx_q <= ovf & ctrl_q.tx_clk_en;
    end

  always_comb begin
    unique case (reg_addr)
      ADDR_CTRL:   reg_rdata = ctrl_q;
      ADDR_CNT_HI: reg_rdata = count_q[15:8];
      ADDR_CNT_LO: reg_rdata = count_q[7:0];
      ADDR_RLD_HI: reg_rdata = reload_q[15:8];
      ADDR_RLD_LO: reg_rdata = reload_q[7:0];
      default:     reg_rdata = 8'h00;
    endcase
  end

  assign irq     = ctrl_q.ovf_flag | ctrl_q.ext_flag;
  assign rx_baud = rx_q;
  assign tx_baud = tx_q;
endmodule

// File: rtl/cr_timer16_chk.sv
module cr_timer16_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [7:0]  reg_addr,
  input logic [7:0]  reg_wdata,
  input logic [7:0]  ctrl,
  input logic [15:0] count,
  input logic [15:0] reload,
  input logic        irq,
  input logic        rx_baud,
  input logic        tx_baud
);
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ctrl[2]) && !$past(reg_wr) && !$past(ctrl[3])) |-> $stable(count)); // R3

  AST_NO_OVF_IN_BAUD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl[7]) |-> !$past(ctrl[5] | ctrl[4])); // R10

  AST_EXT_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl[6]) |-> ($past(ctrl[3]) && !$past(ctrl[5] | ctrl[4]))); // R7

  AST_OVF_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl[7]) |-> $past(reg_wr && reg_addr == 8'hC8 && !reg_wdata[7])); // R11

  AST_EXT_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl[6]) |-> $past(reg_wr && reg_addr == 8'hC8 && !reg_wdata[6])); // R11

  AST_RX_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    rx_baud |-> $past(ctrl[5])); // R10

  AST_TX_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    tx_baud |-> $past(ctrl[4])); // R10

  AST_BAUD_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_baud || tx_baud) && !$past(reg_wr)) |-> (count == $past(reload))); // R10

  AST_SW_WINS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_wr && reg_addr == 8'hCC) |-> (count[7:0] == $past(reg_wdata))); // R13

  AST_IRQ_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ctrl[7] || ctrl[6])); // R12
endmodule

bind cr_timer16 cr_timer16_chk i_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .ctrl(ctrl_q), .count(count_q), .reload(reload_q),
  .irq(irq), .rx_baud(rx_baud), .tx_baud(tx_baud));

// File: tb/test_cr_timer16.sv
module test_cr_timer16;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       cnt_pin = 1'b1;
  logic       trig_pin = 1'b1;
  logic       irq, rx_baud, tx_baud;
  int         n_chk = 0;
  int         n_bad = 0;

  always #10 clk = ~clk;

  cr_timer16 i_cr_timer16 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_pin(cnt_pin),
    .trig_pin(trig_pin), .irq(irq), .rx_baud(rx_baud), .tx_baud(tx_baud));

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic rd16(input logic [7:0] hi, output logic [15:0] v);
    logic [7:0] h, l;
    rd(hi, h); rd(hi - 8'h1, l); v = {h, l};
  endtask

  task automatic set16(input logic [7:0] hi, input logic [15:0] v);
    wr(hi - 8'h1, v[7:0]); wr(hi, v[15:8]);
  endtask

  task automatic pulse(input bit trig);
    if (trig) trig_pin = 1'b0; else cnt_pin = 1'b0;
    repeat (3) @(negedge clk);
    trig_pin = 1'b1; cnt_pin = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual %h expected %h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v, v0;
    int          rxn, txn;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    foreach (v0[i]) ;
    for (int a = 8'hCA; a <= 8'hCD; a++) begin
      rd(a[7:0], b); check(b == 8'h00, "R1", {8'h0, b}, 16'h0);
    end
    rd(8'hC8, b); check(b == 8'h00, "R1", {8'h0, b}, 16'h0);
    check({irq, rx_baud, tx_baud} == 3'b000, "R1", {13'h0, irq, rx_baud, tx_baud}, 16'h0);

    // R2 map and unmapped read
    set16(8'hCB, 16'hA55A); rd16(8'hCB, v);
    check(v == 16'hA55A, "R2", v, 16'hA55A);
    rd(8'hC9, b); check(b == 8'h00, "R2", {8'h0, b}, 16'h0);

    // R3 timer sweep
    foreach (v0[i]) ;
    for (int s = 0; s < 3; s++) begin
      for (int k = 0; k < 3; k++) begin
        automatic logic [15:0] st = (s == 0) ? 16'h0000 : (s == 1) ? 16'h1234 : 16'h7FF0;
        automatic int n = (k == 0) ? 1 : (k == 1) ? 5 : 17;
        wr(8'hC8, 8'h00);
        set16(8'hCD, st);
        wr(8'hC8, 8'h04);
        repeat (n) @(negedge clk);
        rd16(8'hCD, v);
        check(v == st + 16'(n), "R3 count", v, st + 16'(n));
      end
    end
    rd16(8'hCD, v0);
    wr(8'hC8, 8'h00);
    repeat (5) @(negedge clk);
    rd16(8'hCD, v);
    check(v == v0 + 16'h1, "R3 stop", v, v0 + 16'h1);

    // R13 write beats increment
    set16(8'hCD, 16'h2200);
    wr(8'hC8, 8'h04);
    @(negedge clk);
    wr(8'hCC, 8'h50);
    rd16(8'hCD, v);
    check(v == 16'h2250, "R13", v, 16'h2250);

    // R4 counter mode latency and sweep
    wr(8'hC8, 8'h00);
    set16(8'hCD, 16'h0000);
    wr(8'hC8, 8'h06);
    repeat (4) @(negedge clk);
    rd16(8'hCD, v); check(v == 16'h0, "R4 idle", v, 16'h0);
    cnt_pin = 1'b0;
    repeat (2) @(negedge clk);
    rd16(8'hCD, v); check(v == 16'h0, "R4 early", v, 16'h0);
    @(negedge clk);
    rd16(8'hCD, v); check(v == 16'h1, "R4 due", v, 16'h1);
    repeat (3) @(negedge clk);
    cnt_pin = 1'b1;
    repeat (3) @(negedge clk);
    for (int p = 0; p < 6; p++) pulse(1'b0);
    rd16(8'hCD, v); check(v == 16'h7, "R4 sweep", v, 16'h7);

    // R5 wrap in capture-select mode, R11, R12
    wr(8'hC8, 8'h00);
    set16(8'hCD, 16'hFFFD);
    wr(8'hC8, 8'h05);
    repeat (3) @(negedge clk);
    rd16(8'hCD, v); check(v == 16'h0000, "R5 wrap", v, 16'h0);
    rd(8'hC8, b); check(b == 8'h85, "R5 flag", {8'h0, b}, 16'h85);
    check(irq == 1'b1, "R12 set", {15'h0, irq}, 16'h1);
    wr(8'hC8, 8'h81);
    rd(8'hC8, b); check(b == 8'h81, "R11 keep", {8'h0, b}, 16'h81);
    wr(8'hC8, 8'h00);
    rd(8'hC8, b); check(b == 8'h00, "R11 clear", {8'h0, b}, 16'h0);
    check(irq == 1'b0, "R12 clear", {15'h0, irq}, 16'h0);
    wr(8'hC8, 8'h80);
    rd(8'hC8, b); check(b == 8'h00, "R11 no set", {8'h0, b}, 16'h0);

    // R6 auto-reload
    set16(8'hCB, 16'h1234);
    set16(8'hCD, 16'hFFFD);
    wr(8'hC8, 8'h04);
    repeat (3) @(negedge clk);
    rd16(8'hCD, v); check(v == 16'h1234, "R6 reload", v, 16'h1234);
    rd(8'hC8, b); check(b[7] == 1'b1, "R6 flag", {8'h0, b}, 16'h84);
    @(negedge clk);
    rd16(8'hCD, v); check(v == 16'h1235, "R6 next", v, 16'h1235);
    wr(8'hC8, 8'h00);

    // R7 capture
    set16(8'hCD, 16'hABCD);
    set16(8'hCB, 16'h0000);
    wr(8'hC8, 8'h09);
    pulse(1'b1);
    rd16(8'hCB, v); check(v == 16'hABCD, "R7 capture", v, 16'hABCD);
    rd(8'hC8, b); check(b == 8'h49, "R7 flag", {8'h0, b}, 16'h49);
    check(irq == 1'b1, "R12 ext", {15'h0, irq}, 16'h1);
    wr(8'hC8, 8'h00);

    // R8 trigger reload
    set16(8'hCB, 16'h4321);
    set16(8'hCD, 16'h0007);
    wr(8'hC8, 8'h08);
    pulse(1'b1);
    rd16(8'hCD, v); check(v == 16'h4321, "R8 reload", v, 16'h4321);
    rd(8'hC8, b); check(b == 8'h48, "R8 flag", {8'h0, b}, 16'h48);

    // R9 trigger ignored
    wr(8'hC8, 8'h01);
    set16(8'hCD, 16'h0077);
    pulse(1'b1);
    rd16(8'hCD, v); check(v == 16'h0077, "R9 count", v, 16'h0077);
    rd16(8'hCB, v); check(v == 16'h4321, "R9 reload", v, 16'h4321);
    rd(8'hC8, b); check(b == 8'h01, "R9 flags", {8'h0, b}, 16'h01);

    // R10 baud modes: reload FFFE gives an overflow every 2 edges
    for (int m = 0; m < 2; m++) begin
      wr(8'hC8, 8'h00);
      set16(8'hCB, 16'hFFFE);
      set16(8'hCD, 16'hFFFE);
      wr(8'hC8, (m == 0) ? 8'h2C : 8'h1D);
      rxn = 0; txn = 0;
      trig_pin = 1'b0;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        rxn += int'(rx_baud); txn += int'(tx_baud);
      end
      trig_pin = 1'b1;
      check(rxn == ((m == 0) ? 10 : 0), "R10 rx", 16'(rxn), (m == 0) ? 16'd10 : 16'd0);
      check(txn == ((m == 0) ? 0 : 10), "R10 tx", 16'(txn), (m == 0) ? 16'd0 : 16'd10);
      rd(8'hC8, b); check(b[7:6] == 2'b00, "R10 flags", {8'h0, b}, 16'h0);
      rd16(8'hCB, v); check(v == 16'hFFFE, "R10 no capture", v, 16'hFFFE);
    end
    wr(8'hC8, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule